// File: doc/BRIEF.md
# Integer ALU with Compares and Registered Result

This block is the integer arithmetic unit of a small load-store processor. Each accepted cycle it takes two 32-bit operands, a 4-bit operation code, a 16-bit immediate with a flag that selects it in place of operand B, and a 5-bit shift amount. It then produces a 32-bit result, a zero flag for branch decisions and a signed-overflow flag. All three are captured in an output register one clock edge later. Multiply and divide are not part of it.

Immediate extension is done inside the block, ahead of the datapath. Arithmetic and compare operations see a sign-extended immediate. Logical operations see a zero-extended one. The upper-immediate operation always consumes the immediate field. Shifts always act on operand A.

Top module: `int_alu_core`

## Requirements
- R1: Operation codes are 0 ADD, 1 ADDU, 2 SUB, 3 SUBU. Each yields A plus B or A minus B, modulo 2^32.
- R2: `ovf` is 1 after ADD (0) or SUB (2) only when the true signed result falls outside the 32-bit two's-complement range. ADDU (1) and SUBU (3) never raise it, and no other code raises it.
- R3: Code 8 (signed compare) and code 9 (unsigned compare) each yield 1 when A is less than B and 0 otherwise. All bits above bit 0 are zero.
- R4: Code 4 gives A AND B, code 5 gives A OR B, code 6 gives A XOR B, and code 7 gives NOT(A OR B).
- R5: Code 10 shifts A left by `shamt`. Code 11 shifts A right by `shamt` and fills with zeros. Code 12 shifts A right by `shamt` and fills with copies of bit 31. Shifts ignore `use_imm`.
- R6: With `use_imm`=1, B is replaced by `imm`. For codes 4 to 7 the immediate is zero-extended. For codes 0 to 3, 8 and 9 it is sign-extended, so an unsigned compare against 0xFFFF compares with 0xFFFFFFFF.
- R7: Code 13 yields `imm` in bits 31..16 with bits 15..0 cleared, whatever `use_imm` is. Codes 14 and 15 yield 0.
- R8: `zero` is 1 exactly when the registered `result` is 0.
- R9: The operation accepted with `in_valid`=1 at a clock edge appears on `result`, `zero` and `ovf` right after that edge, and `out_valid` is 1 for that cycle only. While `in_valid` is 0, `result`, `zero` and `ovf` keep their values.
- R10: While reset is asserted, `result` is 0, `zero` is 1, and `ovf` and `out_valid` are 0. Reset release is synchronised internally, so operations are accepted from the third clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operation this cycle |
| op | input | 4 | Operation code |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| imm | input | 16 | Immediate field |
| use_imm | input | 1 | Use the extended immediate as B |
| shamt | input | 5 | Shift amount |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered result-is-zero flag |
| ovf | output | 1 | Registered signed-overflow flag |
| out_valid | output | 1 | Result updated this cycle |

## Verification
The hardest cases sit at the edges where the extension rule and the compare or overflow logic interact. One case is an unsigned compare against an immediate with bit 15 set, which must behave as a compare with a huge value. Another is a signed overflow whose wrapped sum looks like an ordinary value. The stimulus reaches these with hand-picked operand pairs at the two's-complement extremes (0x7FFFFFFF, 0x80000000, all-ones). It applies each edge case once with a register B and once with an immediate of the opposite extension rule. A long stream of random operands across every code follows. Idle cycles with changing inputs test that the held outputs stay put.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12,
    OP_LUI  = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_mode_e;

  function automatic logic is_logic_op(alu_op_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR) || (o == OP_NOR);
  endfunction
endpackage

// File: rtl/int_alu_opnd_sel.sv
module int_alu_opnd_sel
  import int_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   opb,
  input  logic [IW-1:0]  imm,
  input  logic           use_imm,
  output logic [W-1:0]   b_eff
);
  localparam int PAD = W - IW;

  logic [W-1:0] imm_sx;
  logic [W-1:0] imm_zx;

  always_comb begin
    imm_sx = {{PAD{imm[IW-1]}}, imm};
    imm_zx = {{PAD{1'b0}}, imm};
    if (!use_imm)
      b_eff = opb;
    else if (is_logic_op(op))
      b_eff = imm_zx;
    else
      b_eff = imm_sx;
  end
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf_raw,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W:0]   full;
  logic [W-1:0] b_in;

  always_comb begin
    b_in    = sub ? ~b : b;
    full    = {1'b0, a} + {1'b0, b_in} + {{W{1'b0}}, sub};
    sum     = full[W-1:0];
    ovf_raw = (a[W-1] == b_in[W-1]) && (sum[W-1] != a[W-1]);
    lt_u    = ~full[W];
    lt_s    = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
  import int_alu_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] amt,
  input  shift_mode_e   mode,
  output logic [W-1:0]  y
);
  logic          left;
  logic          fill;
  logic [W-1:0]  pre;
  logic [W-1:0]  stg [SW+1];

  assign left = (mode == SH_LEFT);
  assign fill = (mode == SH_RARI) ? a[W-1] : 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_pre
    assign pre[i] = left ? a[W-1-i] : a[i];
  end

  assign stg[0] = pre;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
  end

  for (genvar i = 0; i < W; i++) begin : g_post
    assign y[i] = left ? stg[SW][W-1-i] : stg[SW][i];
  end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
  import int_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  result,
  output logic          zero,
  output logic          ovf,
  output logic          out_valid
);
  localparam int LOW = W - IW;

  alu_op_e      op_e;
  logic         rst_meta;
  logic         rst_ok;
  logic [W-1:0] b_eff;
  logic         do_sub;
  logic [W-1:0] sum;
  logic         ovf_raw;
  logic         lt_s;
  logic         lt_u;
  logic [W-1:0] log_y;
  logic [W-1:0] sh_y;
  shift_mode_e  sh_mode;
  logic [W-1:0] res_n;
  logic         ovf_n;
  logic         zero_n;
  logic         en;
  logic [W-1:0] res_q;
  logic         zero_q;
  logic         ovf_q;
  logic         vld_q;

  assign op_e = alu_op_e'(op);

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  int_alu_opnd_sel #(.W(W), .IW(IW)) u_sel (
    .op(op_e), .opb(opb), .imm(imm), .use_imm(use_imm), .b_eff(b_eff)
  );

  assign do_sub = (op_e == OP_SUB) || (op_e == OP_SUBU) ||
                  (op_e == OP_SLT) || (op_e == OP_SLTU);

  int_alu_addsub #(.W(W)) u_addsub (
    .a(opa), .b(b_eff), .sub(do_sub), .sum(sum),
    .ovf_raw(ovf_raw), .lt_s(lt_s), .lt_u(lt_u)
  );

  int_alu_logic #(.W(W)) u_logic (
    .op(op_e), .a(opa), .b(b_eff), .y(log_y)
  );

  always_comb begin
    unique case (op_e)
      OP_SRL:  sh_mode = SH_RLOG;
      OP_SRA:  sh_mode = SH_RARI;
      default: sh_mode = SH_LEFT;
    endcase
  end

  int_alu_shift #(.W(W)) u_shift (
    .a(opa), .amt(shamt), .mode(sh_mode), .y(sh_y)
  );

  // next-state: result selection
  always_comb begin
    ovf_n = 1'b0;
    unique case (op_e)
      OP_ADD, OP_SUB: begin
        res_n = sum;
        ovf_n = ovf_raw;
      end
      OP_ADDU, OP_SUBU:                res_n = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:   res_n = log_y;
      OP_SLT:                          res_n = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                         res_n = {{(W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA:          res_n = sh_y;
      OP_LUI:                          res_n = {imm, {LOW{1'b0}}};
      default:                         res_n = '0;
    endcase
    zero_n = (res_n == '0);
    en     = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      res_q  <= '0;
      zero_q <= 1'b1;
      ovf_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= en;
      if (en) begin
        res_q  <= res_n;
        zero_q <= zero_n;
        ovf_q  <= ovf_n;
      end
    end
  end

  assign result    = res_q;
  assign zero      = zero_q;
  assign ovf       = ovf_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W  = 32,
  parameter int IW = 16,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [W-1:0]  opa,
  input logic [IW-1:0] imm,
  input logic [SW-1:0] shamt,
  input logic [W-1:0]  result,
  input logic          zero,
  input logic          ovf,
  input logic          out_valid
);
  // R2: unsigned add/sub never flag overflow
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && (op == 4'd1 || op == 4'd3) |=> !ovf);

  // R3: compares produce a single-bit value
  p_cmp_bool_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && (op == 4'd8 || op == 4'd9) |=> result[W-1:1] == '0);

  // R5: logical right shift by a nonzero amount clears the top bit
  p_srl_fill_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && op == 4'd11 && shamt != '0 |=> !result[W-1]);

  // R5: arithmetic right shift keeps the sign bit
  p_sra_sign_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && op == 4'd12 |=> result[W-1] == $past(opa[W-1]));

  // R7: upper-immediate placement
  p_upper_imm_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && op == 4'd13 |=> result == {$past(imm), {(W-IW){1'b0}}});

  // R8: zero flag matches registered result
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    zero == (result == '0));

  // R9: outputs hold while idle, valid follows acceptance
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(result) && $stable(ovf) && !out_valid);

  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);
endmodule

bind int_alu_core int_alu_chk #(.W(W), .IW(IW)) chk_i (
  .clk(clk), .rst_ok(rst_ok), .in_valid(in_valid), .op(op), .opa(opa),
  .imm(imm), .shamt(shamt), .result(result), .zero(zero), .ovf(ovf),
  .out_valid(out_valid)
);

// File: tb/int_alu_core_tb_top.sv
`timescale 1ns/1ps
module int_alu_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [15:0] imm;
  logic        use_imm;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        zero;
  logic        ovf;
  logic        out_valid;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] last_res;
  logic        last_ovf;

  int_alu_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa),
    .opb(opb), .imm(imm), .use_imm(use_imm), .shamt(shamt),
    .result(result), .zero(zero), .ovf(ovf), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=done");
      finish_run();
    end
  end

  function automatic void model(input logic [3:0] o, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic ui,
      input logic [4:0] sh, output logic [31:0] r, output logic v);
    logic [31:0] bx;
    longint s;
    v = 1'b0;
    if (ui) bx = (o >= 4 && o <= 7) ? {16'h0, im} : {{16{im[15]}}, im};
    else    bx = b;
    case (o)
      4'd0: begin r = a + bx; s = longint'($signed(a)) + longint'($signed(bx));
                  v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd1: r = a + bx;
      4'd2: begin r = a - bx; s = longint'($signed(a)) - longint'($signed(bx));
                  v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd3: r = a - bx;
      4'd4: r = a & bx;
      4'd5: r = a | bx;
      4'd6: r = a ^ bx;
      4'd7: r = ~(a | bx);
      4'd8: r = ($signed(a) < $signed(bx)) ? 32'd1 : 32'd0;
      4'd9: r = (a < bx) ? 32'd1 : 32'd0;
      4'd10: r = a << sh;
      4'd11: r = a >> sh;
      4'd12: r = $unsigned($signed(a) >>> sh);
      4'd13: r = {im, 16'h0};
      default: r = 32'h0;
    endcase
  endfunction

  task automatic drive(string req, logic [3:0] o, logic [31:0] a, logic [31:0] b,
      logic [15:0] im, logic ui, logic [4:0] sh);
    exp_t e;
    @(negedge clk);
    op = o; opa = a; opb = b; imm = im; use_imm = ui; shamt = sh;
    in_valid = 1'b1;
    model(o, a, b, im, ui, sh, e.res, e.ovf);
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = ~opa; opb = opb + 32'd7; imm = ~imm; op = op + 4'd1;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R9", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "result", result, e.res);
        check(e.req, "ovf", {31'd0, ovf}, {31'd0, e.ovf});
        check("R8", "zero", {31'd0, zero}, {31'd0, (e.res == 32'd0)});
        last_res = e.res;
        last_ovf = e.ovf;
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; opa = '0; opb = '0;
    imm = '0; use_imm = 1'b0; shamt = '0;
    repeat (3) @(negedge clk);
    check("R10", "reset result", result, 32'h0);
    check("R10", "reset zero", {31'd0, zero}, 32'd1);
    check("R10", "reset ovf", {31'd0, ovf}, 32'd0);
    check("R10", "reset out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R2 add and subtract corners
    drive("R2", 4'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R2", 4'd0, 32'h80000000, 32'hFFFFFFFF, 16'h0, 1'b0, 5'd0);
    drive("R2", 4'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R2", 4'd2, 32'h80000000, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R2", 4'd3, 32'h80000000, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R1", 4'd2, 32'h5, 32'h5, 16'h0, 1'b0, 5'd0);
    drive("R1", 4'd3, 32'h0, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R6", 4'd0, 32'h10, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    drive("R6", 4'd0, 32'h7FFFFFF0, 32'h0, 16'h0010, 1'b1, 5'd0);
    // R3 compares
    drive("R3", 4'd8, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R3", 4'd9, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R3", 4'd8, 32'h7FFFFFFF, 32'h80000000, 16'h0, 1'b0, 5'd0);
    drive("R3", 4'd9, 32'h3, 32'h3, 16'h0, 1'b0, 5'd0);
    drive("R6", 4'd8, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    drive("R6", 4'd9, 32'h5, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    // R4 logic, R6 zero extension
    drive("R4", 4'd4, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 1'b0, 5'd0);
    drive("R4", 4'd5, 32'hF0F0F0F0, 32'h0F0F0F0F, 16'h0, 1'b0, 5'd0);
    drive("R4", 4'd6, 32'hAAAA5555, 32'hFFFF0000, 16'h0, 1'b0, 5'd0);
    drive("R4", 4'd7, 32'h0, 32'h0, 16'h0, 1'b0, 5'd0);
    drive("R6", 4'd4, 32'hFFFFFFFF, 32'h0, 16'h8000, 1'b1, 5'd0);
    drive("R6", 4'd5, 32'h0, 32'h0, 16'hF00F, 1'b1, 5'd0);
    drive("R6", 4'd6, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    // R5 shifts
    drive("R5", 4'd10, 32'h1, 32'h0, 16'h0, 1'b0, 5'd31);
    drive("R5", 4'd11, 32'h80000000, 32'h0, 16'h0, 1'b0, 5'd31);
    drive("R5", 4'd12, 32'h80000000, 32'h0, 16'h0, 1'b0, 5'd31);
    drive("R5", 4'd12, 32'h40000000, 32'h0, 16'h0, 1'b0, 5'd4);
    drive("R5", 4'd10, 32'h12345678, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    drive("R5", 4'd11, 32'hF000000F, 32'h0, 16'h0, 1'b0, 5'd4);
    // R7 upper immediate and reserved codes
    drive("R7", 4'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 1'b0, 5'd0);
    drive("R7", 4'd13, 32'h0, 32'h0, 16'h8001, 1'b1, 5'd0);
    drive("R7", 4'd14, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R7", 4'd15, 32'h1, 32'h1, 16'h0, 1'b0, 5'd0);
    drive("R2", 4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h0, 1'b0, 5'd0);

    // R9 hold while idle with changing inputs
    idle(3);
    check("R9", "held result", result, last_res);
    check("R9", "held ovf", {31'd0, ovf}, {31'd0, last_ovf});
    check("R9", "out_valid low when idle", {31'd0, out_valid}, 32'd0);

    // random stream across all codes
    for (int i = 0; i < 400; i++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 15));
      drive((o <= 3) ? "R1" : (o <= 7) ? "R4" : (o <= 9) ? "R3" : (o <= 12) ? "R5" : "R7",
            o, $urandom, $urandom, 16'($urandom), 1'($urandom), 5'($urandom));
      if (i % 37 == 0) idle(1);
    end
    idle(3);
    check("R9", "all results delivered", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule